// File: doc/BRIEF.md
# Seeded Rateless Packet Encoder

This block turns a short message, held as K equal symbols in an internal buffer, into an open-ended stream of coded packets for an erasure channel. Each packet is the XOR of a set of distinct source symbols. The set is chosen by a pseudo-random sequence that is reloaded from a 16-bit per-packet seed. The packet carries that seed, so a receiver can regenerate the same set and solve for the message once it holds a little more than K packets.

Software or an upstream engine first fills the buffer through a byte-strobed write port. It then pulses `start` with an initial seed. The encoder keeps producing packets on a valid/ready stream until `ack` reports that the far end has decoded. A sender normally lets at least K plus ten percent of K packets go out before expecting that acknowledge.

Top module: `lt_fountain_enc`

## Requirements
- R1: While reset is asserted, and after reset until `start` is pulsed, `out_valid` is low.
- R2: A write stores `wr_data` into symbol `wr_addr`. Each byte lane whose `wr_strb` bit is 0 is stored as zero, which zero-pads a short final symbol. The written contents are used by every packet begun after the write.
- R3: A `start` pulse while idle loads `start_seed` as the seed of the first packet. A zero seed is replaced by 0x0001.
- R4: Each packet reloads a 16-bit Galois LFSR from its seed. One step shifts right and XORs 0xB400 when the bit shifted out is 1. The first step after reload chooses the degree, and each later step draws one index.
- R5: The degree comes from bits [3:0] of the first stepped value: 0–3 gives 1, 4–8 gives 2, 9–11 gives 3, 12–13 gives 4, and 14–15 gives 8. The result is clamped to at most K.
- R6: Each draw takes index = (LFSR value mod K). An index already chosen is skipped and drawn again, until exactly degree distinct symbols are chosen. Bit i of `out_mask` is 1 exactly when symbol i was chosen.
- R7: `out_data` is the bitwise XOR of the chosen symbols.
- R8: Each accepted packet (valid and ready high together) advances the seed by one. After 0xFFFF the seed goes to 0x0001, so a packet never carries seed zero.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_seed`, `out_mask` and `out_data` hold steady.
- R10: Without `ack`, packets continue without end. After `ack` is high for a cycle while running, the packet in progress still completes and is delivered, and then no further packet appears until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Symbol buffer write enable |
| wr_addr | input | $clog2(K) | Symbol index written |
| wr_strb | input | SYM_W/8 | Byte lanes kept; others stored as zero |
| wr_data | input | SYM_W | Symbol write data |
| start | input | 1 | Begin generation (sampled when idle) |
| start_seed | input | 16 | Seed of the first packet |
| ack | input | 1 | Receiver acknowledge; stop after current packet |
| out_ready | input | 1 | Downstream can accept a packet |
| out_valid | output | 1 | Packet available |
| out_seed | output | 16 | Seed that produced this packet |
| out_mask | output | K | Chosen source symbols, bit i for symbol i |
| out_data | output | SYM_W | XOR of the chosen symbols |

## Verification
A packet's latency depends on its degree and on how many redraws occur, so the bench does not tie payload checks to fixed cycle numbers. It compares each accepted packet, in acceptance order, with a behavioural model evaluated at the seed due next. A stalled packet must look the same one clock later. This hold is checked on every falling edge that follows a cycle with valid high and ready low. Stopping is checked by counting acceptances: exactly one more packet is due after `ack`, whether `ack` arrives during generation or while a packet is stalled, and then a 300-cycle window must stay silent. Writes are due by the next packet begun after the write, so the bench changes the buffer only while the encoder is idle.

// File: rtl/lt_fountain_pkg.sv
`timescale 1ns/1ps
package lt_fountain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DEG,
    ST_SEL,
    ST_OUT
  } enc_state_t;

  localparam int          PRNG_W    = 16;
  localparam logic [15:0] PRNG_TAPS = 16'hB400;

  // one Galois step, right shift
  function automatic logic [15:0] prng_advance(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ PRNG_TAPS) : (s >> 1);
  endfunction

  // cumulative degree table indexed by a 4-bit draw
  function automatic logic [3:0] degree_lookup(input logic [3:0] r);
    logic [3:0] d;
    if (r < 4'd4)       d = 4'd1;
    else if (r < 4'd9)  d = 4'd2;
    else if (r < 4'd12) d = 4'd3;
    else if (r < 4'd14) d = 4'd4;
    else                d = 4'd8;
    return d;
  endfunction

endpackage

// File: rtl/lt_symbol_store.sv
`timescale 1ns/1ps
module lt_symbol_store #(
  parameter int K     = 8,
  parameter int SYM_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(K)-1:0]     wr_addr,
  input  logic [SYM_W/8-1:0]       wr_strb,
  input  logic [SYM_W-1:0]         wr_data,
  input  logic [$clog2(K)-1:0]     rd_addr,
  output logic [SYM_W-1:0]         rd_data
);
  localparam int LANES = SYM_W / 8;

  logic [SYM_W-1:0] sym_q [K];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < K; i++) sym_q[i] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < LANES; b++)
        sym_q[wr_addr][b*8 +: 8] <= wr_strb[b] ? wr_data[b*8 +: 8] : 8'h00;
    end
  end

  assign rd_data = sym_q[rd_addr];

endmodule

// File: rtl/lt_prng.sv
`timescale 1ns/1ps
module lt_prng
  import lt_fountain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [PRNG_W-1:0] load_val,
  input  logic              step_en,
  output logic [PRNG_W-1:0] next_val
);
  logic [PRNG_W-1:0] state_q;

  assign next_val = prng_advance(state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= '0;
    else if (load_en) state_q <= load_val;
    else if (step_en) state_q <= next_val;
  end

endmodule

// File: rtl/lt_fountain_enc.sv
`timescale 1ns/1ps
module lt_fountain_enc
  import lt_fountain_pkg::*;
#(
  parameter int K     = 8,
  parameter int SYM_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [$clog2(K)-1:0]  wr_addr,
  input  logic [SYM_W/8-1:0]    wr_strb,
  input  logic [SYM_W-1:0]      wr_data,
  input  logic                  start,
  input  logic [15:0]           start_seed,
  input  logic                  ack,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [15:0]           out_seed,
  output logic [K-1:0]          out_mask,
  output logic [SYM_W-1:0]      out_data
);
  localparam int IW = $clog2(K);
  localparam int CW = $clog2(K + 1);

  enc_state_t        st_q, st_n;
  logic [15:0]       seed_q, seed_n;
  logic [CW-1:0]     deg_q, deg_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [K-1:0]      mask_q, mask_n;
  logic [SYM_W-1:0]  acc_q, acc_n;
  logic              stop_q, stop_n;

  logic              prng_load, prng_step;
  logic [15:0]       prng_next;
  logic [IW-1:0]     sel_idx;
  logic [SYM_W-1:0]  sel_sym;
  logic [3:0]        deg_raw;

  lt_prng u_prng (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (prng_load),
    .load_val (seed_q),
    .step_en  (prng_step),
    .next_val (prng_next)
  );

  lt_symbol_store #(.K(K), .SYM_W(SYM_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_strb (wr_strb),
    .wr_data (wr_data),
    .rd_addr (sel_idx),
    .rd_data (sel_sym)
  );

  assign sel_idx = IW'(prng_next % 16'(K));
  assign deg_raw = degree_lookup(prng_next[3:0]);

  always_comb begin
    st_n      = st_q;
    seed_n    = seed_q;
    deg_n     = deg_q;
    cnt_n     = cnt_q;
    mask_n    = mask_q;
    acc_n     = acc_q;
    stop_n    = stop_q | (ack && (st_q != ST_IDLE));
    prng_load = 1'b0;
    prng_step = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          seed_n = (start_seed == 16'h0000) ? 16'h0001 : start_seed;
          stop_n = 1'b0;
          st_n   = ST_LOAD;
        end
      end
      ST_LOAD: begin
        prng_load = 1'b1;
        mask_n    = '0;
        acc_n     = '0;
        cnt_n     = '0;
        st_n      = ST_DEG;
      end
      ST_DEG: begin
        prng_step = 1'b1;
        if (int'(deg_raw) > K) deg_n = CW'(K);
        else                   deg_n = CW'(deg_raw);
        st_n = ST_SEL;
      end
      ST_SEL: begin
        prng_step = 1'b1;
        if (!mask_q[sel_idx]) begin
          mask_n[sel_idx] = 1'b1;
          acc_n           = acc_q ^ sel_sym;
          cnt_n           = cnt_q + CW'(1);
          if (cnt_q + CW'(1) == deg_q) st_n = ST_OUT;
        end
      end
      ST_OUT: begin
        if (out_ready) begin
          seed_n = (seed_q == 16'hFFFF) ? 16'h0001 : seed_q + 16'h0001;
          if (stop_q || ack) begin
            st_n   = ST_IDLE;
            stop_n = 1'b0;
          end else begin
            st_n = ST_LOAD;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      stop_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      stop_q <= stop_n;
    end
  end

  logic seed_en, pkt_en;
  assign seed_en = (st_q == ST_IDLE) || (st_q == ST_OUT);
  assign pkt_en  = (st_q == ST_LOAD) || (st_q == ST_DEG) || (st_q == ST_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seed_q <= '0;
    else if (seed_en) seed_q <= seed_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deg_q  <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
      acc_q  <= '0;
    end else if (pkt_en) begin
      deg_q  <= deg_n;
      cnt_q  <= cnt_n;
      mask_q <= mask_n;
      acc_q  <= acc_n;
    end
  end

  assign out_valid = (st_q == ST_OUT);
  assign out_seed  = seed_q;
  assign out_mask  = mask_q;
  assign out_data  = acc_q;

endmodule

// File: rtl/lt_fountain_enc_chk.sv
`timescale 1ns/1ps
module lt_fountain_enc_chk #(
  parameter int K     = 8,
  parameter int SYM_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [15:0]      out_seed,
  input logic [K-1:0]     out_mask,
  input logic [SYM_W-1:0] out_data
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (!out_valid);
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_seed) &&
                                   $stable(out_mask) && $stable(out_data)));

  // R8
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_seed != 16'h0000));

  // R8
  seed_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (out_seed != $past(out_seed)));

  // R6
  mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0));

endmodule

bind lt_fountain_enc lt_fountain_enc_chk #(.K(K), .SYM_W(SYM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_seed  (out_seed),
  .out_mask  (out_mask),
  .out_data  (out_data)
);

// File: tb/lt_fountain_enc_bench.sv
`timescale 1ns/1ps
module lt_fountain_enc_bench;
  localparam int K     = 8;
  localparam int SYM_W = 32;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [2:0]        wr_addr;
  logic [3:0]        wr_strb;
  logic [31:0]       wr_data;
  logic              start;
  logic [15:0]       start_seed;
  logic              ack;
  logic              out_ready;
  logic              out_valid;
  logic [15:0]       out_seed;
  logic [K-1:0]      out_mask;
  logic [31:0]       out_data;

  lt_fountain_enc #(.K(K), .SYM_W(SYM_W)) u_lt_fountain_enc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_strb(wr_strb), .wr_data(wr_data), .start(start),
    .start_seed(start_seed), .ack(ack), .out_ready(out_ready),
    .out_valid(out_valid), .out_seed(out_seed), .out_mask(out_mask),
    .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit [31:0] ref_mem [K];
  int        exp_seed;
  int        xfer_cnt = 0;
  int        cyc = 0;
  bit        run_mon = 0;
  bit        hold_ready = 0;
  bit        pend = 0;
  bit        rdy;
  logic [15:0]  p_seed;
  logic [K-1:0] p_mask;
  logic [31:0]  p_data;
  bit [K-1:0]   em;
  bit [31:0]    ed;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int lstep(input int s);
    int lsb = s & 1;
    s = s >> 1;
    if (lsb != 0) s = s ^ 'hB400;
    return s;
  endfunction

  function automatic int pick_degree(input int r);
    int d;
    if (r < 4) d = 1;
    else if (r < 9) d = 2;
    else if (r < 12) d = 3;
    else if (r < 14) d = 4;
    else d = 8;
    return (d > K) ? K : d;
  endfunction

  task automatic model(input int seed, output bit [K-1:0] m, output bit [31:0] d);
    int s = lstep(seed);
    int deg = pick_degree(s & 15);
    int n = 0;
    m = '0;
    d = '0;
    while (n < deg) begin
      int i;
      s = lstep(s);
      i = s % K;
      if (!m[i]) begin
        m[i] = 1'b1;
        d = d ^ ref_mem[i];
        n++;
      end
    end
  endtask

  always @(negedge clk) begin
    if (run_mon) begin
      cyc++;
      rdy = !hold_ready && ((cyc % 5) != 2);
      if (pend) begin
        check(out_valid && out_seed == p_seed && out_mask == p_mask && out_data == p_data,
              "R9 stall hold", {out_seed, out_mask, out_data}, {p_seed, p_mask, p_data});
        pend = 0;
      end
      out_ready = rdy;
      if (out_valid) begin
        if (rdy) begin
          model(exp_seed, em, ed);
          check(out_seed == 16'(exp_seed), "R3 R8 seed", out_seed, exp_seed);
          check(out_mask == em, "R4 R5 R6 mask", out_mask, em);
          check(out_data == ed, "R2 R7 payload", out_data, ed);
          exp_seed = (exp_seed == 'hFFFF) ? 1 : exp_seed + 1;
          xfer_cnt++;
        end else begin
          pend   = 1;
          p_seed = out_seed;
          p_mask = out_mask;
          p_data = out_data;
        end
      end
    end
  end

  task automatic write_sym(input int a, input bit [3:0] s, input bit [31:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = 3'(a); wr_strb = s; wr_data = d;
    for (int b = 0; b < 4; b++) ref_mem[a][b*8 +: 8] = s[b] ? d[b*8 +: 8] : 8'h00;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic kick(input bit [15:0] sd);
    exp_seed = (sd == 0) ? 1 : int'(sd);
    @(negedge clk); #1;
    start = 1; start_seed = sd;
    @(negedge clk); #1;
    start = 0;
  endtask

  task automatic pulse_ack();
    ack = 1;
    @(negedge clk); #1;
    ack = 0;
  endtask

  task automatic expect_stop(input int base, input string tag);
    repeat (300) @(negedge clk);
    #1;
    check(xfer_cnt == base + 1, tag, xfer_cnt, base + 1);
    check(!out_valid, "R10 idle after stop", out_valid, 0);
  endtask

  initial begin
    int base;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_strb = 0; wr_data = 0;
    start = 0; start_seed = 0; ack = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    check(!out_valid, "R1 valid in reset", out_valid, 0);
    #1 rst_n = 1;
    repeat (10) @(negedge clk);
    check(!out_valid, "R1 idle without start", out_valid, 0);
    run_mon = 1;

    for (int i = 0; i < K - 1; i++) write_sym(i, 4'hF, 32'hA5C30000 ^ (i * 32'h01010101) ^ (32'h1 << (3*i)));
    write_sym(K - 1, 4'b0011, 32'hDEADBEEF);
    write_sym(2, 4'b1010, 32'h11223344);

    // seed wraps FFFE, FFFF, 0001 (R8); ack while generating (R10)
    kick(16'hFFFE);
    while (!(xfer_cnt >= 20 && !out_valid)) begin @(negedge clk); #1; end
    base = xfer_cnt;
    pulse_ack();
    expect_stop(base, "R10 ack mid-packet");

    // zero start seed becomes 1 (R3); ack during a stall (R10)
    kick(16'h0000);
    while (xfer_cnt < base + 7) begin @(negedge clk); #1; end
    hold_ready = 1;
    while (!(out_valid && !out_ready)) begin @(negedge clk); #1; end
    base = xfer_cnt;
    pulse_ack();
    repeat (4) @(negedge clk);
    #1 hold_ready = 0;
    expect_stop(base, "R10 ack while stalled");

    // buffer rewrite reaches next packets (R2)
    write_sym(0, 4'b0000, 32'hFFFFFFFF);
    write_sym(5, 4'b0100, 32'h12345678);
    kick(16'h1234);
    while (!(xfer_cnt >= base + 14 && !out_valid)) begin @(negedge clk); #1; end
    base = xfer_cnt;
    pulse_ack();
    expect_stop(base, "R10 third run stop");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule